// File: doc/BRIEF.md
# Posted PCI Write Target Sequencer

This block is the control half of a PCI target that accepts memory writes into a posting buffer. It watches the bus for the start of a transaction, waits for an external address decode to claim it, and then runs the target handshake. Alongside every bus phase it issues a 4-bit command to a separate data-path slice, which holds the address, moves it into the posting buffer, and posts each accepted data word. The data path is the only part that knows how far the burst has advanced within a buffer line. It raises a line-end warning, and the sequencer answers that warning with a disconnect.

No data passes through this block, so it has no valid/ready streams. Every pin is a plain control level. PCI signals appear here with active-high polarity, and conversion from the active-low bus pins happens outside the block. All outputs are registered, so each reacts one clock after the inputs that cause it are sampled. The decode wait is bounded by the parameter `DEC_WAIT`. If no memory select arrives within that bound, the sequencer gives up without ever asserting TRDY.

Top module: `pci_post_wr_seq`

## Requirements
- R1: While reset is asserted and in the first clock after it, `cmd_o` carries the idle code, and `trdy_o` and `stop_o` are 0.
- R2: When idle, a clock edge that samples `frame_i` at 1 after it was 0 at the previous edge makes `cmd_o` carry the hold-address code in the next clock. That code repeats every clock while the select is awaited. Idle clocks ignore `irdy_i`, `mem_sel_i` and `line_end_i`.
- R3: `mem_sel_i` sampled at 1 while awaiting the select makes `trdy_o` 1 in the next clock, and in that clock only, `cmd_o` carries the post-address code.
- R4: Every edge that samples `trdy_o` and `irdy_i` both at 1 is a transfer, and `cmd_o` carries the post-data code in the next clock. A data-phase clock that follows an edge without a transfer carries the idle code.
- R5: `line_end_i` sampled at 1 during a data phase while `frame_i` is still 1 makes `trdy_o` 0 and `stop_o` 1 in the next clock.
- R6: `line_end_i` sampled at 1 at any edge while the select is awaited is remembered. The first data-phase clock is then the only clock with TRDY, and STOP follows it, whether or not a transfer took place.
- R7: `stop_o` stays 1 until an edge samples `frame_i` at 0. In the clock after that edge `stop_o` is 0 and the block is idle.
- R8: A transfer edge that samples `frame_i` at 0 ends the transaction. In the next clock `trdy_o` is 0 and `stop_o` stays 0, and this outcome takes precedence over a line end seen at the same edge.
- R9: If the select is not seen within `DEC_WAIT` hold-address clocks, the block returns to idle with the idle code and never asserts TRDY. A `frame_i` still held at 1 does not start a new transaction.
- R10: The command codes are parameters, with defaults idle 4'h0, hold-address 4'h5, post-address 4'h8 and post-data 4'h9. `trdy_o` and `stop_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | PCI FRAME, active high |
| irdy_i | input | 1 | PCI IRDY, active high |
| mem_sel_i | input | 1 | Address decode claims the transaction |
| line_end_i | input | 1 | Data path warns that the buffer line ends |
| cmd_o | output | 4 | Command to the data-path slice |
| trdy_o | output | 1 | PCI TRDY, active high |
| stop_o | output | 1 | PCI STOP, active high |

## Verification
The bench builds the block with `DEC_WAIT` = 3. This makes it practical to sweep every select delay up to the last accepted clock and then one past it, into the timeout. Burst lengths of one to four words are combined with IRDY wait-state masks, and a line end is placed on every transfer of those bursts, including the last one, where the master's own completion must win. The line-end warning is also raised during the decode wait at each select delay, both with and without a transfer in the single remaining data phase.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_SEL,
    ST_DATA,
    ST_DISC
  } seq_state_e;
endpackage

// File: rtl/pwseq_sel_timer.sv
module pwseq_sel_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  // R9: the wait never runs past its bound
  a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/pwseq_end_flag.sv
module pwseq_end_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic line_end_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (arm_i) pend_q <= pend_q | line_end_i;
    else            pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R6: a warning seen during the wait is kept
  a_r6_warning_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && line_end_i) |=> pend_q);
endmodule

// File: rtl/pwseq_ctrl.sv
module pwseq_ctrl
  import pwseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_i,
  input  logic       irdy_i,
  input  logic       mem_sel_i,
  input  logic       line_end_i,
  input  logic       pend_i,
  input  logic       expired_i,
  output seq_state_e st_q_o,
  output seq_state_e st_d_o,
  output logic       xfer_o,
  output logic       trdy_o,
  output logic       stop_o
);
  seq_state_e st_q, st_d;
  logic       frame_q, trdy_q, stop_q, xfer;

  assign xfer = trdy_q && irdy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (frame_i && !frame_q) st_d = ST_WAIT_SEL;
      ST_WAIT_SEL: begin
        if (mem_sel_i)      st_d = ST_DATA;
        else if (expired_i) st_d = ST_IDLE;
      end
      ST_DATA: begin
        if (xfer && !frame_i)          st_d = ST_IDLE;
        else if (line_end_i || pend_i) st_d = ST_DISC;
      end
      ST_DISC:     if (!frame_i) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b0;
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_i;
      trdy_q  <= (st_d == ST_DATA);
      stop_q  <= (st_d == ST_DISC);
    end
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;
  assign xfer_o = xfer;
  assign trdy_o = trdy_q;
  assign stop_o = stop_q;

  // R10: handshake outputs are exclusive
  a_r10_trdy_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trdy_q && stop_q));

  // R3: TRDY only rises after a sampled select
  a_r3_trdy_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_q) |-> $past(mem_sel_i));

  // R5: a line end during a continuing burst disconnects
  a_r5_line_end_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_q && line_end_i && frame_i) |=> (stop_q && !trdy_q));

  // R7: STOP holds while FRAME stays asserted
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && frame_i) |=> stop_q);

  // R8: a final transfer ends quietly
  a_r8_master_end: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !frame_i) |=> (!trdy_q && !stop_q));
endmodule

// File: rtl/pwseq_cmd_gen.sv
module pwseq_cmd_gen
  import pwseq_pkg::*;
#(
  parameter logic [CMD_W-1:0] CMD_NOP       = 4'h0,
  parameter logic [CMD_W-1:0] CMD_HOLD_ADDR = 4'h5,
  parameter logic [CMD_W-1:0] CMD_POST_ADDR = 4'h8,
  parameter logic [CMD_W-1:0] CMD_POST_DATA = 4'h9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       st_q_i,
  input  seq_state_e       st_d_i,
  input  logic             xfer_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;

  always_comb begin
    if (xfer_i)                                       cmd_d = CMD_POST_DATA;
    else if (st_q_i == ST_WAIT_SEL && st_d_i == ST_DATA) cmd_d = CMD_POST_ADDR;
    else if (st_d_i == ST_WAIT_SEL)                   cmd_d = CMD_HOLD_ADDR;
    else                                              cmd_d = CMD_NOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_NOP;
    else        cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  // R4: each transfer is posted in the following clock
  a_r4_post_each_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> (cmd_q == CMD_POST_DATA));

  // R3: the address is posted on entry to the data phase only
  a_r3_addr_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_POST_ADDR) |-> ((st_q_i == ST_DATA) && ($past(st_q_i) == ST_WAIT_SEL)));
endmodule

// File: rtl/pci_post_wr_seq.sv
module pci_post_wr_seq
  import pwseq_pkg::*;
#(
  parameter int              DEC_WAIT      = 8,
  parameter logic [CMD_W-1:0] CMD_NOP       = 4'h0,
  parameter logic [CMD_W-1:0] CMD_HOLD_ADDR = 4'h5,
  parameter logic [CMD_W-1:0] CMD_POST_ADDR = 4'h8,
  parameter logic [CMD_W-1:0] CMD_POST_DATA = 4'h9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic             mem_sel_i,
  input  logic             line_end_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             trdy_o,
  output logic             stop_o
);
  seq_state_e st_q, st_d;
  logic       xfer, pend, expired;

  pwseq_sel_timer #(.LIMIT(DEC_WAIT)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (st_q == ST_WAIT_SEL),
    .expired_o (expired)
  );

  pwseq_end_flag flag_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (st_q == ST_WAIT_SEL),
    .line_end_i (line_end_i),
    .pend_o     (pend)
  );

  pwseq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .irdy_i     (irdy_i),
    .mem_sel_i  (mem_sel_i),
    .line_end_i (line_end_i),
    .pend_i     (pend),
    .expired_i  (expired),
    .st_q_o     (st_q),
    .st_d_o     (st_d),
    .xfer_o     (xfer),
    .trdy_o     (trdy_o),
    .stop_o     (stop_o)
  );

  pwseq_cmd_gen #(
    .CMD_NOP       (CMD_NOP),
    .CMD_HOLD_ADDR (CMD_HOLD_ADDR),
    .CMD_POST_ADDR (CMD_POST_ADDR),
    .CMD_POST_DATA (CMD_POST_DATA)
  ) cmd_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_q_i (st_q),
    .st_d_i (st_d),
    .xfer_i (xfer),
    .cmd_o  (cmd_o)
  );

  // R9: TRDY is never raised straight out of idle
  a_r9_no_trdy_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> !trdy_o);

  // R2: the hold code appears only while the select is awaited
  a_r2_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_HOLD_ADDR) |-> (st_q == ST_WAIT_SEL));
endmodule

// File: tb/pci_post_wr_seq_tb.sv
module pci_post_wr_seq_tb_top;
  localparam int W = 3;
  localparam logic [3:0] NOP  = 4'h0;
  localparam logic [3:0] HOLD = 4'h5;
  localparam logic [3:0] ADDR = 4'h8;
  localparam logic [3:0] DATA = 4'h9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_i = 1'b0, irdy_i = 1'b0, mem_sel_i = 1'b0, line_end_i = 1'b0;
  logic [3:0] cmd_o;
  logic trdy_o, stop_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pci_post_wr_seq #(
    .DEC_WAIT(W), .CMD_NOP(NOP), .CMD_HOLD_ADDR(HOLD),
    .CMD_POST_ADDR(ADDR), .CMD_POST_DATA(DATA)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i),
    .mem_sel_i(mem_sel_i), .line_end_i(line_end_i),
    .cmd_o(cmd_o), .trdy_o(trdy_o), .stop_o(stop_o)
  );

  task automatic chk(input logic [3:0] ec, input logic et, input logic es, input string req);
    n_chk++;
    if (cmd_o !== ec || trdy_o !== et || stop_o !== es) begin
      n_fail++;
      $display("FAIL %s: cmd=%h trdy=%b stop=%b, expected cmd=%h trdy=%b stop=%b",
               req, cmd_o, trdy_o, stop_o, ec, et, es);
    end
  endtask

  // d: wait clock in which the select is given; n: words the master sends;
  // gap: IRDY wait mask per data clock; eol_x: transfer index with line end (-1 none)
  task automatic run_txn(input int d, input int n, input logic [7:0] gap,
                         input int eol_x, input bit eol_dec, input bit hold_stop);
    int xfers = 0;
    int j = 0;
    bit prev_x = 0;
    bit hit = 0;
    bit fin = 0;
    frame_i = 1; irdy_i = 0; mem_sel_i = 0; line_end_i = 0;
    @(negedge clk);
    for (int k = 0; k <= d; k++) begin
      chk(HOLD, 1'b0, 1'b0, "R2");
      line_end_i = eol_dec && (k == 0);
      mem_sel_i  = (k == d);
      @(negedge clk);
    end
    mem_sel_i = 0; line_end_i = 0;
    while (!fin) begin
      bit x;
      chk((j == 0) ? ADDR : (prev_x ? DATA : NOP), 1'b1, 1'b0, (j == 0) ? "R3" : "R4");
      x = !gap[j % 8] || (j >= 8);
      irdy_i = x;
      if (x && xfers == n - 1) frame_i = 0;
      if (x && xfers == eol_x) begin line_end_i = 1; hit = 1; end
      @(negedge clk);
      line_end_i = 0; irdy_i = 0;
      if (x) xfers++;
      prev_x = x;
      j++;
      if (!frame_i) begin
        chk(DATA, 1'b0, 1'b0, "R8");
        @(negedge clk);
        chk(NOP, 1'b0, 1'b0, "R8");
        fin = 1;
      end else if (hit || (eol_dec && j == 1)) begin
        chk(prev_x ? DATA : NOP, 1'b0, 1'b1, eol_dec ? "R6" : "R5");
        if (hold_stop) begin
          @(negedge clk);
          chk(NOP, 1'b0, 1'b1, "R7");
        end
        frame_i = 0;
        @(negedge clk);
        chk(NOP, 1'b0, 1'b0, "R7");
        fin = 1;
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    chk(NOP, 1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(NOP, 1'b0, 1'b0, "R1");

    // R2: idle ignores everything but FRAME
    irdy_i = 1; mem_sel_i = 1; line_end_i = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(NOP, 1'b0, 1'b0, "R2");
    end
    irdy_i = 0; mem_sel_i = 0; line_end_i = 0;
    @(negedge clk);

    // R3 R4 R8: select delay and burst length sweep
    for (int d = 0; d < W; d++)
      for (int n = 1; n <= 4; n++)
        run_txn(d, n, 8'h00, -1, 0, 0);

    // R4: IRDY wait states
    run_txn(0, 3, 8'h02, -1, 0, 0);
    run_txn(1, 3, 8'h05, -1, 0, 0);
    run_txn(2, 3, 8'h0A, -1, 0, 0);
    run_txn(0, 2, 8'h03, -1, 0, 0);

    // R5 R7 R8: line end on every transfer position
    for (int n = 2; n <= 4; n++)
      for (int e = 0; e < n; e++)
        run_txn(1, n, 8'h00, e, 0, e[0]);
    run_txn(0, 4, 8'h05, 2, 0, 1);

    // R6: line end during the decode wait
    for (int d = 0; d < W; d++)
      run_txn(d, 3, 8'h00, -1, 1, 1);
    run_txn(1, 3, 8'h01, -1, 1, 0);
    run_txn(0, 1, 8'h00, -1, 1, 0);

    // R9: no select within the wait bound
    frame_i = 1; irdy_i = 1;
    @(negedge clk);
    for (int k = 0; k < W; k++) begin
      chk(HOLD, 1'b0, 1'b0, "R9");
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      chk(NOP, 1'b0, 1'b0, "R9");
      @(negedge clk);
    end
    frame_i = 0; irdy_i = 0;
    @(negedge clk);
    chk(NOP, 1'b0, 1'b0, "R9");

    // R10: a normal transaction after the timeout
    run_txn(2, 2, 8'h00, -1, 0, 0);
    summary();
  end
endmodule